// File: doc/BRIEF.md
# PFC Enable and Fault Sequencer

This block is a clocked supervisor that decides when a downstream power-factor-correction (PFC) stage may run, relative to the main PWM converter it sits beside. It watches four conditions: supply readiness, a peak-current-limit error flag, skip-cycle activity from light-load regulation, and a hard latch-off fault. It drives a PFC enable, a pair of PWM mode controls and a fault indication.

The enable rules are deliberately uneven. The PFC starts only once the PWM has reached regulation, which shows as the error flag going low. Dropping into standby needs skip activity to last a full confirmation window. Returning from standby is instant. Two persistence timers supply the confirmation windows. The first turns a long-lived current-limit error into a short-circuit fault, which then runs in auto-recovery burst. The second turns long-lived skip activity into standby. A latch-off fault overrides everything, and only a reset clears it.

The window length is `CLK_HZ / 1000 * CONFIRM_MS` clock cycles, written N below. The default gives 100 ms at 50 MHz.

Top module: `pfc_sequencer`

## Requirements
- R1: While the sequencer is in STARTUP, `pwm_run` is 1 and `pfc_en` is 0. It stays in STARTUP as long as `cur_err` is high, and moves to NORMAL, with `pfc_en` set to 1, on the first clock edge that samples `cur_err` low.
- R2: In STARTUP, NORMAL, STANDBY_PENDING and STANDBY, the state becomes FAULT_BURST on the Nth consecutive clock edge that samples `cur_err` high. Until that edge the state does not change because of the error.
- R3: In FAULT_BURST the outputs are `pwm_run`=0, `pwm_burst`=1, `fault_flag`=1 and `pfc_en`=0.
- R4: FAULT_BURST is left for STARTUP on the first edge that samples `cur_err` low, with `pfc_en` still 0. The path back to NORMAL then follows R1.
- R5: An error that drops before N edges clears the persistence count. A new error needs a full N edges of its own.
- R6: In NORMAL, sampling `skip_act` high moves the state to STANDBY_PENDING, and `pfc_en` stays 1. If `skip_act` stays high for N more edges, the state becomes STANDBY and `pfc_en` becomes 0. If `skip_act` drops earlier, the state returns to NORMAL.
- R7: In STANDBY, the first edge that samples `skip_act` low moves the state to NORMAL, so `pfc_en` is 1 right after that edge.
- R8: If `latch_in` is high at an edge, the state becomes LATCHED. LATCHED gives `pfc_en`=0, `pwm_run`=0, `pwm_burst`=0 and `fault_flag`=1, ignores every input and is left only through `rst_n`.
- R9: Outside LATCHED, sampling `pwr_good` low returns the state to RESET, where all outputs are 0. A later `pwr_good` high moves RESET to STARTUP.
- R10: `state_o` carries the following codes: RESET=0, STARTUP=1, NORMAL=2, STANDBY_PENDING=3, STANDBY=4, FAULT_BURST=5, LATCHED=6. Reset gives RESET.
- R11: `pfc_en` is never 1 in a cycle unless `pwm_run` was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Supply above its start threshold |
| cur_err | input | 1 | Peak-current-limit error flag |
| skip_act | input | 1 | Skip-cycle activity present |
| latch_in | input | 1 | Latch-off fault request (over-voltage or over-temperature) |
| pfc_en | output | 1 | Permission for the PFC stage to run |
| pwm_run | output | 1 | PWM converter switching normally |
| pwm_burst | output | 1 | PWM in fault auto-recovery burst |
| fault_flag | output | 1 | Fault burst or latch-off active |
| state_o | output | 3 | Sequencer state code (R10) |

## Verification
The hardest case to reach is the boundary of each confirmation window. An error or skip episode that ends one edge before the window expires must leave the state untouched. One that lasts exactly to the window must flip it, and exactly on that edge. The bench reaches both boundaries by sweeping the episode length from 1 to beyond N, with a ten-cycle window. For each length it predicts, edge by edge, the state and the enable. A separate pair of nearly full error pulses, split by a one-cycle gap, shows that the count restarts.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_STARTUP  = 3'd1,
    ST_NORMAL   = 3'd2,
    ST_STBY_PND = 3'd3,
    ST_STANDBY  = 3'd4,
    ST_FAULT    = 3'd5,
    ST_LATCHED  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/persist_timer.sv
// Counts consecutive enabled cycles; done on the N-th enabled edge.
module persist_timer #(
  parameter int unsigned N = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)               cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
  import pfc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       cur_err,
  input  logic       skip_act,
  input  logic       latch_in,
  input  logic       err_done,
  input  logic       skip_done,
  output logic       err_tmr_en,
  output logic       skip_tmr_en,
  output seq_state_e state_q
);
  seq_state_e state_d;
  logic       active;

  assign active = (state_q == ST_STARTUP) || (state_q == ST_NORMAL) ||
                  (state_q == ST_STBY_PND) || (state_q == ST_STANDBY);
  assign err_tmr_en  = active && cur_err;
  assign skip_tmr_en = (state_q == ST_STBY_PND) && skip_act;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_LATCHED) begin
      state_d = ST_LATCHED;
    end else if (latch_in) begin
      state_d = ST_LATCHED;
    end else if (!pwr_good) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:    state_d = ST_STARTUP;
        ST_STARTUP:  if (err_done)       state_d = ST_FAULT;
                     else if (!cur_err)  state_d = ST_NORMAL;
        ST_NORMAL:   if (err_done)       state_d = ST_FAULT;
                     else if (skip_act)  state_d = ST_STBY_PND;
        ST_STBY_PND: if (err_done)       state_d = ST_FAULT;
                     else if (!skip_act) state_d = ST_NORMAL;
                     else if (skip_done) state_d = ST_STANDBY;
        ST_STANDBY:  if (err_done)       state_d = ST_FAULT;
                     else if (!skip_act) state_d = ST_NORMAL;
        ST_FAULT:    if (!cur_err)       state_d = ST_STARTUP;
        default:     state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pfc_seq_outdec.sv
module pfc_seq_outdec
  import pfc_seq_pkg::*;
(
  input  seq_state_e state_q,
  output logic       pfc_en,
  output logic       pwm_run,
  output logic       pwm_burst,
  output logic       fault_flag
);
  always_comb begin
    pfc_en     = 1'b0;
    pwm_run    = 1'b0;
    pwm_burst  = 1'b0;
    fault_flag = 1'b0;
    unique case (state_q)
      ST_STARTUP:  pwm_run = 1'b1;
      ST_NORMAL,
      ST_STBY_PND: begin pwm_run = 1'b1; pfc_en = 1'b1; end
      ST_STANDBY:  pwm_run = 1'b1;
      ST_FAULT:    begin pwm_burst = 1'b1; fault_flag = 1'b1; end
      ST_LATCHED:  fault_flag = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/pfc_sequencer.sv
module pfc_sequencer
  import pfc_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned CONFIRM_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       cur_err,
  input  logic       skip_act,
  input  logic       latch_in,
  output logic       pfc_en,
  output logic       pwm_run,
  output logic       pwm_burst,
  output logic       fault_flag,
  output logic [2:0] state_o
);
  localparam int unsigned CONFIRM_CYCLES = (CLK_HZ / 1000) * CONFIRM_MS;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic       err_en, skip_en, err_done, skip_done;
  seq_state_e state_q;

  persist_timer #(.N(CONFIRM_CYCLES)) u_err_tmr (
    .clk(clk), .rst_n(rst_sync_n), .en(err_en), .done(err_done)
  );

  persist_timer #(.N(CONFIRM_CYCLES)) u_skip_tmr (
    .clk(clk), .rst_n(rst_sync_n), .en(skip_en), .done(skip_done)
  );

  pfc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .pwr_good(pwr_good), .cur_err(cur_err), .skip_act(skip_act),
    .latch_in(latch_in), .err_done(err_done), .skip_done(skip_done),
    .err_tmr_en(err_en), .skip_tmr_en(skip_en), .state_q(state_q)
  );

  pfc_seq_outdec u_dec (
    .state_q(state_q), .pfc_en(pfc_en), .pwm_run(pwm_run),
    .pwm_burst(pwm_burst), .fault_flag(fault_flag)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pfc_sequencer_chk.sv
module pfc_sequencer_chk #(
  parameter int unsigned N = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       cur_err,
  input logic       skip_act,
  input logic       latch_in,
  input logic       pfc_en,
  input logic       pwm_run,
  input logic       pwm_burst,
  input logic       fault_flag,
  input logic [2:0] state_o
);
  localparam int unsigned CW = $clog2(N + 2);
  localparam logic [2:0] S_RST = 3'd0, S_SU = 3'd1, S_NOR = 3'd2, S_PND = 3'd3,
                         S_STB = 3'd4, S_FLT = 3'd5, S_LAT = 3'd6;

  logic          act;
  logic [CW-1:0] err_run, skip_run;
  assign act = (state_o == S_SU) || (state_o == S_NOR) ||
               (state_o == S_PND) || (state_o == S_STB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_run  <= '0;
      skip_run <= '0;
    end else begin
      if (act && cur_err) err_run <= (err_run == CW'(N)) ? err_run : err_run + 1'b1;
      else                err_run <= '0;
      if (skip_act && (state_o == S_NOR || state_o == S_PND))
        skip_run <= (skip_run == CW'(N + 1)) ? skip_run : skip_run + 1'b1;
      else
        skip_run <= '0;
    end
  end

  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SU && cur_err) |=> !pfc_en); // R1
  AST_FAULT_ENTRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_FLT && $past(state_o) != S_FLT && $past(state_o) != S_LAT)
      |-> (err_run == CW'(N))); // R2
  AST_FAULT_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cur_err && pwr_good && !latch_in && err_run == CW'(N - 1))
      |=> (state_o == S_FLT)); // R2
  AST_BURST_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_FLT) |-> (pwm_burst && fault_flag && !pwm_run && !pfc_en)); // R3
  AST_BURST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_FLT && !cur_err && pwr_good && !latch_in) |=> (state_o == S_SU)); // R4
  AST_STANDBY_ENTRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_STB && $past(state_o) == S_PND) |-> (skip_run == CW'(N + 1))); // R6
  AST_STANDBY_EXIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_STB && !skip_act && !cur_err && pwr_good && !latch_in) |=> pfc_en); // R7
  AST_LATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_in |=> (state_o == S_LAT)); // R8
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_LAT) |=> (state_o == S_LAT && fault_flag && !pfc_en && !pwm_run)); // R8
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !latch_in && state_o != S_LAT) |=> (state_o == S_RST)); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= S_LAT); // R10
  AST_PFC_AFTER_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_en |-> $past(pwm_run)); // R11
endmodule

bind pfc_sequencer pfc_sequencer_chk #(.N(CONFIRM_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pwr_good(pwr_good), .cur_err(cur_err),
  .skip_act(skip_act), .latch_in(latch_in), .pfc_en(pfc_en), .pwm_run(pwm_run),
  .pwm_burst(pwm_burst), .fault_flag(fault_flag), .state_o(state_o)
);

// File: tb/pfc_sequencer_bench.sv
module pfc_sequencer_bench;
  localparam int N = 10;  // CLK_HZ=1000, CONFIRM_MS=10
  localparam int S_RST = 0, S_SU = 1, S_NOR = 2, S_PND = 3, S_STB = 4, S_FLT = 5, S_LAT = 6;

  logic clk = 1'b0;
  logic rst_n, pwr_good, cur_err, skip_act, latch_in;
  logic pfc_en, pwm_run, pwm_burst, fault_flag;
  logic [2:0] state_o;
  int n_chk = 0, n_err = 0;
  logic prev_run;

  always #10 clk = ~clk;

  pfc_sequencer #(.CLK_HZ(1000), .CONFIRM_MS(10)) u_pfc_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cur_err(cur_err),
    .skip_act(skip_act), .latch_in(latch_in), .pfc_en(pfc_en), .pwm_run(pwm_run),
    .pwm_burst(pwm_burst), .fault_flag(fault_flag), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    prev_run = pwm_run;
    @(posedge clk);
    #1;
    chk(!pfc_en || prev_run, "R11", int'(pfc_en), int'(prev_run));
  endtask

  task automatic check_st(input int es, input bit ep, input string req);
    chk(int'(state_o) == es, req, int'(state_o), es);
    chk(pfc_en == ep, req, int'(pfc_en), int'(ep));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_good = 1'b0; cur_err = 1'b0; skip_act = 1'b0; latch_in = 1'b0;
    #1;
    check_st(S_RST, 1'b0, "R10");
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    prev_run = 1'b0;
    do_reset();
    check_st(S_RST, 1'b0, "R10");
    chk(!pwm_run && !pwm_burst && !fault_flag, "R9", int'(pwm_run), 0);

    // R1: startup with the error flag held
    pwr_good = 1'b1; cur_err = 1'b1;
    tick();
    check_st(S_SU, 1'b0, "R1");
    chk(pwm_run == 1'b1, "R1", int'(pwm_run), 1);
    for (int j = 1; j <= N - 2; j++) begin
      tick();
      check_st(S_SU, 1'b0, "R1");
    end
    cur_err = 1'b0;
    tick();
    check_st(S_NOR, 1'b1, "R1");

    // R2/R3/R4/R5: sweep of error pulse length
    for (int k = 1; k <= N + 2; k++) begin
      for (int j = 1; j <= k; j++) begin
        cur_err = 1'b1;
        tick();
        if (j < N) check_st(S_NOR, 1'b1, "R2");
        else begin
          check_st(S_FLT, 1'b0, "R2");
          chk(!pwm_run && pwm_burst && fault_flag, "R3", int'(pwm_burst), 1);
        end
      end
      cur_err = 1'b0;
      tick();
      if (k >= N) begin
        check_st(S_SU, 1'b0, "R4");
        tick();
        check_st(S_NOR, 1'b1, "R4");
      end else begin
        check_st(S_NOR, 1'b1, "R5");
      end
    end

    // R5: two near-full pulses split by one low cycle
    for (int p = 0; p < 2; p++) begin
      cur_err = 1'b1;
      repeat (N - 1) tick();
      check_st(S_NOR, 1'b1, "R5");
      cur_err = 1'b0;
      tick();
      check_st(S_NOR, 1'b1, "R5");
    end

    // R6/R7: sweep of skip activity length
    for (int k = 1; k <= N + 3; k++) begin
      for (int j = 1; j <= k; j++) begin
        skip_act = 1'b1;
        tick();
        if (j <= N) check_st(S_PND, 1'b1, "R6");
        else        check_st(S_STB, 1'b0, "R6");
      end
      skip_act = 1'b0;
      tick();
      check_st(S_NOR, 1'b1, (k > N) ? "R7" : "R6");
    end

    // R2 in standby: an error still gets confirmed
    skip_act = 1'b1;
    repeat (N + 1) tick();
    check_st(S_STB, 1'b0, "R6");
    cur_err = 1'b1;
    repeat (N) tick();
    check_st(S_FLT, 1'b0, "R2");
    cur_err = 1'b0; skip_act = 1'b0;
    repeat (2) tick();
    check_st(S_NOR, 1'b1, "R4");

    // R9: supply loss
    pwr_good = 1'b0;
    tick();
    check_st(S_RST, 1'b0, "R9");
    chk(!pwm_run && !pwm_burst && !fault_flag, "R9", int'(pwm_run), 0);
    pwr_good = 1'b1;
    tick();
    check_st(S_SU, 1'b0, "R9");
    tick();
    check_st(S_NOR, 1'b1, "R9");

    // R8: latch-off, then every input wiggled
    latch_in = 1'b1;
    tick();
    check_st(S_LAT, 1'b0, "R8");
    chk(fault_flag && !pwm_run && !pwm_burst, "R8", int'(fault_flag), 1);
    latch_in = 1'b0;
    for (int j = 0; j < 16; j++) begin
      pwr_good = j[0]; cur_err = j[1]; skip_act = j[2];
      tick();
      check_st(S_LAT, 1'b0, "R8");
    end
    do_reset();
    check_st(S_RST, 1'b0, "R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule